// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Single-Write Bit Set and Clear

This block is a general-purpose I/O port with sixteen pins and a small memory-mapped register file of 32-bit words. Software programs each pin as a driver or a receiver through two configuration words, reads the pin levels through a synchronized input word, and drives the pins from an output word. The port sits on a simple bus with address, write enable, write data, read enable and read data. Reads are combinational and return data in the same cycle. Writes take effect on the next rising clock edge.

Changing a single output bit through the output word would need a read, a mask and a write. Two write-only command words avoid that. The first can raise and lower any mix of outputs in one write. The second only lowers outputs. In both command words a one bit acts and a zero bit does nothing. Each pin's output enable comes from the two low bits of its four-bit configuration field.

Top module: `gpio_port`

## Requirements
- R1: After reset, every 4-bit pin configuration field holds 0x4, the output word is zero, and `pad_out` and `pad_oe` are all zero.
- R2: The configuration word at byte offset 0x00 covers pins 0..7 and the word at 0x04 covers pins 8..15. Pin n uses bits 4*(n mod 8)+3 down to 4*(n mod 8). Both words read back exactly as written.
- R3: `pad_oe[n]` is 1 when the two low (mode) bits of pin n's field are nonzero, and 0 when they are 00. So 0x3 makes a pin an output, while 0x8, 0x4 and 0xC leave it an input.
- R4: A read at offset 0x08 returns the pad levels in bits 15:0 and zero in bits 31:16. The value shown is what `pad_in` held two rising edges earlier.
- R5: A write at offset 0x0C replaces all 16 output bits with wdata[15:0]. The value shows on `pad_out` after the next edge, and it reads back at 0x0C with bits 31:16 at zero.
- R6: A write at offset 0x10 sets output bit n for each one in wdata[15:0] and clears output bit n for each one in wdata[31:16]. Zero bits leave their outputs unchanged. When both the set bit and the clear bit for a pin are one, the set wins.
- R7: A write at offset 0x14 clears output bit n for each one in wdata[15:0]. Zero bits and bits 31:16 have no effect.
- R8: Offsets 0x10 and 0x14 read as zero. Their effect shows on `pad_out` and in the output word right after the clock edge that takes the write.
- R9: Writes to offsets 0x18 and 0x1C change no state, and reads there return zero. `rdata` is zero whenever `rd_en` is low. The two lowest address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 5 | Byte address of the register |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data, combinational |
| pad_in | input | 16 | Pin levels from the pads |
| pad_out | output | 16 | Output levels to the pads |
| pad_oe | output | 16 | Per-pin driver enable |

## Verification
A wrong bit in the output word shows on `pad_out` at the first negative edge after the write that caused it. Every output command is therefore followed at once by an output-word readback and a comparison at the pins. A bad mode decode shows on `pad_oe` in the cycle after the configuration write. A synchronizer with too many or too few stages shows as an input read that matches the new pad value one edge early or one edge late, so the input word is sampled after one edge and again after two. A command word that leaks into the read mux shows as a nonzero read at offsets 0x10 and 0x14.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int NPIN   = 16,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe
);
  localparam int HALF  = NPIN / 2;
  localparam int CFG_W = 4 * HALF;
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] A_CFGLO = IDX_W'(0);
  localparam logic [IDX_W-1:0] A_CFGHI = IDX_W'(1);
  localparam logic [IDX_W-1:0] A_IN    = IDX_W'(2);
  localparam logic [IDX_W-1:0] A_OUT   = IDX_W'(3);
  localparam logic [IDX_W-1:0] A_SR    = IDX_W'(4);
  localparam logic [IDX_W-1:0] A_CLR   = IDX_W'(5);
  localparam logic [CFG_W-1:0] CFG_RST = {HALF{4'h4}};

  logic [IDX_W-1:0] widx;
  logic [CFG_W-1:0] cfg_lo, cfg_hi;
  logic [NPIN-1:0]  odr, sync1, sync2;
  logic [NPIN-1:0]  set_bits, clr_bits;

  assign widx     = addr[ADDR_W-1:2];
  assign set_bits = wdata[NPIN-1:0];
  assign clr_bits = wdata[2*NPIN-1:NPIN];
  assign pad_out  = odr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_lo <= CFG_RST;
      cfg_hi <= CFG_RST;
    end else if (wr_en) begin
      if (widx == A_CFGLO) cfg_lo <= wdata[CFG_W-1:0];
      if (widx == A_CFGHI) cfg_hi <= wdata[CFG_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) odr <= '0;
    else if (wr_en) begin
      case (widx)
        A_OUT:   odr <= set_bits;
        A_SR:    odr <= (odr & ~clr_bits) | set_bits;
        A_CLR:   odr <= odr & ~set_bits;
        default: odr <= odr;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    sync1 <= pad_in;
    sync2 <= sync1;
  end

  for (genvar i = 0; i < HALF; i++) begin : g_oe
    assign pad_oe[i]      = |cfg_lo[4*i +: 2];
    assign pad_oe[i+HALF] = |cfg_hi[4*i +: 2];
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (widx)
        A_CFGLO: rdata[CFG_W-1:0] = cfg_lo;
        A_CFGHI: rdata[CFG_W-1:0] = cfg_hi;
        A_IN:    rdata[NPIN-1:0]  = sync2;
        A_OUT:   rdata[NPIN-1:0]  = odr;
        default: rdata = '0;
      endcase
    end
  end

  function automatic logic [HALF-1:0] mode_on(input logic [CFG_W-1:0] w);
    logic [HALF-1:0] r;
    for (int k = 0; k < HALF; k++) r[k] = w[4*k] | w[4*k+1];
    return r;
  endfunction

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (pad_out == '0 && pad_oe == '0));

  assert_lo_mode_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == A_CFGLO) |=> pad_oe[HALF-1:0] == mode_on($past(wdata[CFG_W-1:0])));

  assert_hi_mode_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == A_CFGHI) |=> pad_oe[NPIN-1:HALF] == mode_on($past(wdata[CFG_W-1:0])));

  assert_input_lag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && widx == A_IN) |-> (rdata[DATA_W-1:NPIN] == '0 && rdata[NPIN-1:0] == $past(pad_in, 2)));

  assert_out_replace_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == A_OUT) |=> pad_out == $past(wdata[NPIN-1:0]));

  assert_setreset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == A_SR) |=>
      ((pad_out & $past(wdata[NPIN-1:0])) == $past(wdata[NPIN-1:0])) &&
      ((pad_out & $past(wdata[2*NPIN-1:NPIN]) & ~$past(wdata[NPIN-1:0])) == '0) &&
      ((pad_out & ~$past(wdata[NPIN-1:0]) & ~$past(wdata[2*NPIN-1:NPIN])) ==
       ($past(pad_out) & ~$past(wdata[NPIN-1:0]) & ~$past(wdata[2*NPIN-1:NPIN]))));

  assert_clear_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == A_CLR) |=>
      ((pad_out & $past(wdata[NPIN-1:0])) == '0) &&
      ((pad_out & ~$past(wdata[NPIN-1:0])) == ($past(pad_out) & ~$past(wdata[NPIN-1:0]))));

  assert_cmd_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (widx == A_SR || widx == A_CLR)) |-> rdata == '0);

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (widx == A_OUT || widx == A_SR || widx == A_CLR)) |=> $stable(pad_out));

  assert_idle_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0);
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [4:0]  addr = '0;
  logic        wr_en = 0;
  logic [31:0] wdata = '0;
  logic        rd_en = 0;
  logic [31:0] rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_out, pad_oe;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  gpio_port u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
                .rd_en(rd_en), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe));

  // {addr, wdata, expected output word after the write}
  localparam logic [68:0] TBL [14] = '{
    {5'h0C, 32'h0000A5A5, 32'h0000A5A5},
    {5'h0C, 32'hFFFF1234, 32'h00001234},
    {5'h10, 32'h00000C01, 32'h00001E35},
    {5'h10, 32'h00300000, 32'h00001E05},
    {5'h10, 32'h00010000, 32'h00001E04},
    {5'h10, 32'h00010001, 32'h00001E05},
    {5'h14, 32'h00000E00, 32'h00001005},
    {5'h14, 32'hFFFF0000, 32'h00001005},
    {5'h10, 32'h00000000, 32'h00001005},
    {5'h0C, 32'h00000000, 32'h00000000},
    {5'h10, 32'h0000FFFF, 32'h0000FFFF},
    {5'h10, 32'hFFFF0000, 32'h00000000},
    {5'h10, 32'h00008000, 32'h00008000},
    {5'h14, 32'h00008001, 32'h00000000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a; rd_en = 1;
    #1 d = rdata;
    rd_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(5'h00, v); check("R1 cfg lo", v, 32'h44444444);
    rd(5'h04, v); check("R1 cfg hi", v, 32'h44444444);
    rd(5'h0C, v); check("R1 out word", v, 32'h0);
    check("R1 pad_oe", {16'h0, pad_oe}, 32'h0);
    check("R1 pad_out", {16'h0, pad_out}, 32'h0);
    // R9 idle read
    check("R9 rd_en low", rdata, 32'h0);

    // R5 R6 R7 table walk
    for (int i = 0; i < 14; i++) begin
      string req;
      logic [4:0]  ta;
      logic [31:0] td, te;
      {ta, td, te} = TBL[i];
      req = (ta == 5'h0C) ? "R5" : (ta == 5'h10) ? "R6" : "R7";
      wr(ta, td);
      check({req, " pad_out"}, {16'h0, pad_out}, te);
      rd(5'h0C, v); check({req, " out readback"}, v, te);
    end

    // R8 command words read zero, effect right after the edge
    rd(5'h10, v); check("R8 set/clear reads zero", v, 32'h0);
    rd(5'h14, v); check("R8 clear reads zero", v, 32'h0);
    wr(5'h10, 32'h00000042);
    check("R8 effect next edge", {16'h0, pad_out}, 32'h00000042);
    rd(5'h10, v); check("R8 set/clear reads zero after write", v, 32'h0);

    // R2 R3 configuration layout and mode decode
    wr(5'h00, 32'h88033003);
    rd(5'h00, v); check("R2 cfg lo readback", v, 32'h88033003);
    check("R3 oe low pins", {16'h0, pad_oe}, 32'h00000019);
    wr(5'h04, 32'h00000021);
    rd(5'h04, v); check("R2 cfg hi readback", v, 32'h00000021);
    check("R3 oe high pins", {16'h0, pad_oe}, 32'h00000319);
    wr(5'h04, 32'h0000000C);
    check("R3 cfg 0xC is input", {16'h0, pad_oe}, 32'h00000019);
    wr(5'h07, 32'h30000000);
    check("R2 pin 15 field via hi word", {16'h0, pad_oe}, 32'h00008019);
    rd(5'h04, v); check("R9 low addr bits ignored", v, 32'h30000000);

    // R4 input sync lag
    @(negedge clk);
    pad_in = 16'hBEEF;
    @(negedge clk);
    rd(5'h08, v); check("R4 one edge still old", v, 32'h0);
    @(negedge clk);
    rd(5'h08, v); check("R4 two edges shows pad", v, 32'h0000BEEF);
    pad_in = 16'h1357;
    repeat (2) @(negedge clk);
    rd(5'h08, v); check("R4 second pattern", v, 32'h00001357);

    // R9 unmapped offsets
    wr(5'h18, 32'hFFFFFFFF);
    wr(5'h1C, 32'h0000FFFF);
    rd(5'h18, v); check("R9 unmapped read", v, 32'h0);
    rd(5'h1C, v); check("R9 unmapped read hi", v, 32'h0);
    check("R9 out unchanged", {16'h0, pad_out}, 32'h00000042);
    rd(5'h00, v); check("R9 cfg unchanged", v, 32'h88033003);

    // R1 reset again restores defaults
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd(5'h00, v); check("R1 cfg lo after re-reset", v, 32'h44444444);
    check("R1 pad_out after re-reset", {16'h0, pad_out}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule